// File: doc/BRIEF.md
# Pipelined Burst Static RAM

This block is a single-clock static RAM with an 18-bit word made of two 9-bit byte lanes. It samples address, write data and every control pin on the rising clock edge. A read returns its word through an output register, so the data appears one edge after the edge that sampled the address. The output is modelled as a data bus plus a drive-enable pin, which stands in for a three-state bus. Depth is a parameter.

An access starts when either of two start strobes is asserted while all three chip selects are true. Which strobe starts the access changes how writes are handled. After the start, an internal 2-bit counter generates the low two address bits. The advance input steps the counter, and a mode pin picks linear or interleaved order. A strobe sampled while any chip select is false deselects the part, and the output stops driving one edge later.

Data and control are plain pins with no valid/ready handshake. A memory accepts a command on every edge and has no back-pressure.

Top module: `sram_burst_top`

## Requirements
- R1: A read sampled at edge k drives `dout_drv` high after edge k+1, with `dout` equal to the stored word. A write sampled at edge k leaves `dout_drv` low after edge k+1.
- R2: An access starts only when a strobe is sampled with `cs0_n` low, `cs1` high and `cs2_n` low. A strobe sampled with any other combination of the three selects performs no access.
- R3: After a deselecting strobe, and after reset, `dout_drv` is low from the next edge on. Cycles with no strobe perform no access until a new start.
- R4: `oe_n` high forces `dout_drv` low in the same cycle, whatever access is pending.
- R5: A start on `burst_cpu_n` loads `addr` and always reads. The write pins are ignored on that cycle. If both strobes are low, `burst_cpu_n` wins.
- R6: A start on `burst_ctl_n` loads `addr` and obeys the write pins.
- R7: In a cycle with no strobe and `adv_n` low, the burst counter steps by one. With `adv_n` high, the previous address is accessed again.
- R8: With `ord_il` low, the burst's low two address bits are (start + count) mod 4. The upper address bits stay fixed.
- R9: With `ord_il` high, the burst's low two address bits are start XOR count.
- R10: When `bwe_n` is low and `gw_n` is high, only the lanes whose `lane_we_n` bit is low are written. Lane 0 is bits 8:0 and lane 1 is bits 17:9.
- R11: When `gw_n` is low, both lanes are written, whatever `bwe_n` and `lane_we_n` say.
- R12: A cycle with `gw_n` high and either `bwe_n` high or all `lane_we_n` bits high is a read and changes no stored data.
- R13: A strobe during a burst restarts it at the newly sampled address with the count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, loaded on a start |
| burst_cpu_n | input | 1 | Start strobe that always reads, active low |
| burst_ctl_n | input | 1 | Start strobe that obeys the write pins, active low |
| adv_n | input | 1 | Burst counter advance, active low |
| ord_il | input | 1 | Burst order: 0 linear, 1 interleaved |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data from the output register |
| dout_drv | output | 1 | High when `dout` is being driven |

## Verification
A reference array is used throughout, and every expected word is computed from it.

- **Single-address sweeps.** These cover every word:
  - global writes with conflicting byte controls, which must be overridden;
  - starts on the read-only strobe with all write pins active, which must leave memory unchanged;
  - byte writes that cycle through every lane mask, with and without the qualifier.
- **Bursts.** Every start offset is run in both orders, with a hold cycle inside each burst. This tells the order functions apart, and separates stepping from holding.
- **Control corners.** A write burst is read back, and a burst is restarted midway. Each chip select is made false on its own. The output enable is raised while a read is pending.

// File: rtl/sram_burst_pkg.sv
package sram_burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_ord_e;

  localparam int unsigned CNT_W = 2;

  function automatic logic [CNT_W-1:0] burst_low(
    input logic [CNT_W-1:0] start,
    input logic [CNT_W-1:0] count,
    input burst_ord_e       ord
  );
    if (ord == ORD_XOR) return start ^ count;
    return CNT_W'(start + count);
  endfunction

endpackage

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              strobe,
  input  logic              sel_ok,
  input  logic              adv,
  input  burst_ord_e        ord,
  output logic              acc_valid,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [CNT_W-1:0]  cnt_q
);

  logic              active_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_nxt;

  assign cnt_nxt = adv ? CNT_W'(cnt_q + 1'b1) : cnt_q;

  always_comb begin
    if (strobe) begin
      acc_valid = sel_ok;
      acc_addr  = addr;
    end else begin
      acc_valid = active_q;
      acc_addr  = {base_q[ADDR_W-1:CNT_W], burst_low(base_q[CNT_W-1:0], cnt_nxt, ord)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (strobe) begin
      active_q <= sel_ok;
      base_q   <= addr;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_nxt;
    end
  end

endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode #(
  parameter int unsigned LANES = 2
) (
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] lane_we_n,
  input  logic             read_only,
  output logic [LANES-1:0] lanes,
  output logic             wr
);

  always_comb begin
    if (read_only)  lanes = '0;
    else if (!gw_n) lanes = '1;
    else if (!bwe_n) lanes = ~lane_we_n;
    else            lanes = '0;
  end

  assign wr = |lanes;

endmodule

// File: rtl/sram_lane_array.sv
module sram_lane_array #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9
) (
  input  logic              clk,
  input  logic              s_valid,
  input  logic              s_wr,
  input  logic              s_lane_we,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [LANE_W-1:0] s_data,
  output logic [LANE_W-1:0] rd_q
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (s_valid && s_wr && s_lane_we) mem[s_addr] <= s_data;
    if (s_valid && !s_wr)             rd_q        <= mem[s_addr];
  end

endmodule

// File: rtl/sram_burst_top.sv
module sram_burst_top
  import sram_burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 9,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DATA_W = LANE_W * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              burst_cpu_n,
  input  logic              burst_ctl_n,
  input  logic              adv_n,
  input  logic              ord_il,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              oe_n,
  input  logic              gw_n,
  input  logic              bwe_n,
  input  logic [LANES-1:0]  lane_we_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drv
);

  logic              sel_ok, strobe;
  logic              acc_valid;
  logic [ADDR_W-1:0] acc_addr;
  logic [CNT_W-1:0]  cnt_q;
  logic [LANES-1:0]  lanes;
  logic              wr;

  logic              s_valid, s_wr;
  logic [LANES-1:0]  s_lanes;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  logic              out_act_q;

  assign sel_ok = !cs0_n && cs1 && !cs2_n;
  assign strobe = !burst_cpu_n || !burst_ctl_n;

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .strobe    (strobe),
    .sel_ok    (sel_ok),
    .adv       (!adv_n),
    .ord       (burst_ord_e'(ord_il)),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .cnt_q     (cnt_q)
  );

  sram_wr_decode #(.LANES(LANES)) u_dec (
    .gw_n      (gw_n),
    .bwe_n     (bwe_n),
    .lane_we_n (lane_we_n),
    .read_only (!burst_cpu_n),
    .lanes     (lanes),
    .wr        (wr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid   <= 1'b0;
      s_wr      <= 1'b0;
      s_lanes   <= '0;
      s_addr    <= '0;
      s_data    <= '0;
      out_act_q <= 1'b0;
    end else begin
      s_valid   <= acc_valid;
      s_wr      <= wr;
      s_lanes   <= lanes;
      s_addr    <= acc_addr;
      s_data    <= din;
      out_act_q <= s_valid && !s_wr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sram_lane_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_arr (
      .clk       (clk),
      .s_valid   (s_valid),
      .s_wr      (s_wr),
      .s_lane_we (s_lanes[g]),
      .s_addr    (s_addr),
      .s_data    (s_data[g*LANE_W +: LANE_W]),
      .rd_q      (dout[g*LANE_W +: LANE_W])
    );
  end

  assign dout_drv = out_act_q && !oe_n;

endmodule

// File: rtl/sram_burst_chk.sv
module sram_burst_chk #(
  parameter int unsigned LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             burst_cpu_n,
  input logic             burst_ctl_n,
  input logic             adv_n,
  input logic             cs0_n,
  input logic             cs1,
  input logic             cs2_n,
  input logic             gw_n,
  input logic             dout_drv,
  input logic             acc_valid,
  input logic             wr,
  input logic [LANES-1:0] lanes,
  input logic [1:0]       cnt_q
);

  // R3: a deselecting strobe leaves the output undriven after the next edge
  p_deselect_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!burst_cpu_n || !burst_ctl_n) && !(!cs0_n && cs1 && !cs2_n)) |=> ##1 !dout_drv);

  // R1: a write access never drives the output
  p_write_nodrive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && wr) |=> ##1 !dout_drv);

  // R5: the read-only strobe never writes
  p_cpu_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_cpu_n |-> !wr);

  // R11: global write selects every lane
  p_global_lanes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && burst_cpu_n) |-> (lanes == {LANES{1'b1}}));

  // R7: without strobe or advance the counter holds
  p_hold_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_cpu_n && burst_ctl_n && adv_n) |=> $stable(cnt_q));

endmodule

bind sram_burst_top sram_burst_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .burst_cpu_n (burst_cpu_n),
  .burst_ctl_n (burst_ctl_n),
  .adv_n       (adv_n),
  .cs0_n       (cs0_n),
  .cs1         (cs1),
  .cs2_n       (cs2_n),
  .gw_n        (gw_n),
  .dout_drv    (dout_drv),
  .acc_valid   (acc_valid),
  .wr          (wr),
  .lanes       (lanes),
  .cnt_q       (cnt_q)
);

// File: tb/tb_sram_burst_top.sv
module tb_sram_burst_top;

  localparam int AW = 6;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          burst_cpu_n, burst_ctl_n, adv_n, ord_il;
  logic          cs0_n, cs1, cs2_n, oe_n, gw_n, bwe_n;
  logic [1:0]    lane_we_n;
  logic [DW-1:0] din, dout;
  logic          dout_drv;

  sram_burst_top #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .burst_cpu_n(burst_cpu_n),
    .burst_ctl_n(burst_ctl_n), .adv_n(adv_n), .ord_il(ord_il), .cs0_n(cs0_n),
    .cs1(cs1), .cs2_n(cs2_n), .oe_n(oe_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .lane_we_n(lane_we_n), .din(din), .dout(dout), .dout_drv(dout_drv)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  logic [DW-1:0] ref_mem [1<<AW];
  bit            m_active = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  bit            pend_rd = 1'b0;
  logic [DW-1:0] pend_data = '0;
  string         pend_tag = "R3";

  function automatic logic [DW-1:0] pat(input int a);
    return DW'((a * 7919) ^ 18'h2A5A5);
  endfunction

  task automatic idle();
    burst_cpu_n = 1; burst_ctl_n = 1; adv_n = 1; cs0_n = 0; cs1 = 1; cs2_n = 0;
    oe_n = 0; gw_n = 1; bwe_n = 1; lane_we_n = 2'b11; din = '0;
  endtask

  task automatic step(input string tag);
    bit            en, strb, v, cur_rd;
    logic [AW-1:0] ad;
    logic [1:0]    c, lanes;
    logic [DW-1:0] cur_data;
    en   = !cs0_n && cs1 && !cs2_n;
    strb = !burst_cpu_n || !burst_ctl_n;
    if (strb) begin
      v = en; ad = addr; m_active = en; m_base = addr; m_cnt = 0;
    end else begin
      v = m_active;
      c = m_cnt + (adv_n ? 2'd0 : 2'd1);
      ad = {m_base[AW-1:2], ord_il ? (m_base[1:0] ^ c) : 2'(m_base[1:0] + c)};
      if (m_active) m_cnt = c;
    end
    if (!burst_cpu_n)      lanes = 2'b00;
    else if (!gw_n)        lanes = 2'b11;
    else if (!bwe_n)       lanes = ~lane_we_n;
    else                   lanes = 2'b00;
    cur_rd = v && (lanes == 2'b00);
    cur_data = cur_rd ? ref_mem[ad] : '0;
    if (v && lanes[0]) ref_mem[ad][8:0]  = din[8:0];
    if (v && lanes[1]) ref_mem[ad][17:9] = din[17:9];
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if (dout_drv !== (pend_rd && !oe_n) || (dout_drv && dout !== pend_data)) begin
      n_bad++;
      $display("FAIL %s: drv=%0b dout=%05h expected drv=%0b dout=%05h",
               oe_n ? "R4" : pend_tag, dout_drv, dout, pend_rd && !oe_n, pend_data);
    end
    pend_rd = cur_rd; pend_data = cur_data; pend_tag = tag;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: expired, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(); ord_il = 0; addr = '0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    n_chk++;
    if (dout_drv !== 1'b0) begin
      n_bad++; $display("FAIL R3: reset drv=%0b expected 0", dout_drv);
    end

    // R11 with conflicting byte controls, started by R6 strobe
    for (int a = 0; a < (1<<AW); a++) begin
      idle(); burst_ctl_n = 0; addr = AW'(a); gw_n = 0;
      bwe_n = a[0]; lane_we_n = 2'(a); din = pat(a); step("R11");
    end
    // R5: read-only strobe ignores active write pins
    for (int a = 0; a < (1<<AW); a++) begin
      idle(); burst_cpu_n = 0; addr = AW'(a); gw_n = 0; bwe_n = 0;
      lane_we_n = 2'b00; din = '1; step("R5");
    end
    // R10 / R12 byte writes
    for (int a = 0; a < (1<<AW); a++) begin
      idle(); burst_ctl_n = 0; addr = AW'(a); bwe_n = (a % 8) >= 4;
      lane_we_n = ~2'(a % 4); din = pat(a + 100);
      step(((a % 4) == 0 || (a % 8) >= 4) ? "R12" : "R10");
    end
    // R1 / R6 read-back
    for (int a = 0; a < (1<<AW); a++) begin
      idle(); burst_ctl_n = 0; addr = AW'(a); step("R1");
    end
    // R8 / R9 bursts with a hold cycle (R7)
    for (int o = 0; o < 2; o++) begin
      for (int s = 0; s < 4; s++) begin
        ord_il = o[0];
        idle(); burst_ctl_n = 0; addr = {4'(o*2 + 4), 2'(s)}; step(o ? "R9" : "R8");
        idle(); adv_n = 0; step(o ? "R9" : "R8");
        idle(); step("R7");
        idle(); adv_n = 0; step(o ? "R9" : "R8");
        idle(); adv_n = 0; step(o ? "R9" : "R8");
      end
    end
    // write burst in interleaved order, then read back
    ord_il = 1;
    idle(); burst_ctl_n = 0; addr = 6'd41; gw_n = 0; din = pat(500); step("R9");
    for (int k = 1; k < 4; k++) begin
      idle(); adv_n = 0; gw_n = 0; din = pat(500 + k); step("R9");
    end
    for (int a = 40; a < 44; a++) begin
      idle(); burst_cpu_n = 0; addr = AW'(a); step("R9");
    end
    // R13 restart mid-burst
    ord_il = 0;
    idle(); burst_ctl_n = 0; addr = 6'd50; step("R13");
    idle(); adv_n = 0; step("R13");
    idle(); burst_cpu_n = 0; burst_ctl_n = 0; adv_n = 0; addr = 6'd23; gw_n = 0; step("R13");
    idle(); adv_n = 0; step("R13");
    idle(); adv_n = 0; step("R13");
    // R2 / R3 each select false on its own
    for (int k = 0; k < 3; k++) begin
      idle(); burst_ctl_n = 0; addr = 6'd10; step("R2");
      idle(); burst_ctl_n = 0; addr = 6'd11;
      if (k == 0) cs0_n = 1; else if (k == 1) cs1 = 0; else cs2_n = 1;
      step("R2");
      idle(); adv_n = 0; step("R3");
      idle(); gw_n = 0; din = '1; step("R3");
    end
    // R4 output enable
    idle(); burst_ctl_n = 0; addr = 6'd12; step("R4");
    idle(); adv_n = 0; oe_n = 1; step("R4");
    idle(); oe_n = 0; step("R4");
    idle(); step("R4");
    idle(); step("R1");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule